// File: doc/BRIEF.md
# DMA Destination Address Sequencer

This block sits in front of a write DMA engine that streams payload into host or accelerator memory. Before a run, software programs a small table of destination buffers through a word-addressed register port. Each table entry holds a 64-bit base address and a byte length. Software also programs the host address that receives completion words. The run is limited to that table, so no processor step is needed between buffers.

A start command hands control to the sequencer. It issues one fixed-size write burst request per chunk and advances the address after each acknowledged burst. When a buffer is used up, it posts a completion word to the status address and moves to the next entry. After the last entry it returns to entry 0, which gives ping-pong buffering. A stop command ends the run cleanly: any request already on the handshake is allowed to finish, and nothing new is started.

Register words (word address on `regAddr`):
- Entry `i`: word `4*i` holds address bits 31:0, word `4*i+1` holds bits 63:32, and word `4*i+2` holds the length.
- Word `4*ENTRIES` is the command word: bit 0 is start and bit 1 is stop.
- Words `4*ENTRIES+1` and `4*ENTRIES+2` hold the low and high halves of the status address.

Top module: `dma_dest_seq`

## Requirements
- R1: After reset, `reqValid` and `statValid` are low, and they stay low until a start command is written.
- R2: Table entries and the status address are written at the word addresses listed above. Any write to them while a run is active is ignored, and the values already loaded are used.
- R3: A command word with bit 0 set and bit 1 clear, written while idle, starts a run. `reqValid` is high in the cycle after the write is sampled, with `reqAddr` equal to entry 0's base address.
- R4: A request holds `reqAddr` steady until `reqAck`. `reqBytes` always equals BURST_BYTES. The next request for the same buffer uses the previous address plus BURST_BYTES, with full 64-bit carry.
- R5: An entry takes length >> log2(BURST_BYTES) bursts. The length's low bits are ignored, and a length below one burst counts as one burst.
- R6: When the last burst of a buffer is acknowledged, the block raises `statValid` with `statAddr` equal to the status address. `statData[7:0]` holds the index of the finished entry and `statData[31:8]` holds the number of buffers completed so far in the run, this one included. Both are held until `statAck`, and the next buffer's first request follows the acknowledge.
- R7: After entry ENTRIES-1 completes, the sequence continues at entry 0 with its programmed address and length.
- R8: The completion count restarts from zero at every start, so the first completion of each run reports 1.
- R9: After a stop command, the outstanding request still completes at its acknowledge, and no further burst is requested. If that burst ended a buffer, its completion word is still posted; otherwise nothing follows.
- R10: A start written during a run has no effect on the sequence. A stop written while idle, or a command word with both bits set written while idle, starts nothing.
- R11: `reqValid` and `statValid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Register word address |
| regWrData | input | 32 | Register write data |
| reqValid | output | 1 | Burst request pending |
| reqAddr | output | 64 | Burst destination address |
| reqBytes | output | 32 | Burst length in bytes (BURST_BYTES) |
| reqAck | input | 1 | Burst accepted and completed |
| statValid | output | 1 | Completion write pending |
| statAddr | output | 64 | Completion write address |
| statData | output | 32 | Completion payload: count in 31:8, entry index in 7:0 |
| statAck | input | 1 | Completion write accepted |

## Verification
The bench builds the block with ENTRIES=4 and keeps the other defaults (256-byte bursts, 64-bit addresses). With four entries, a wrap back to entry 0 and a second lap take only about ten bursts. The entries mix a two-burst length, a one-burst length, a length with stray low bits, a zero length, and a base address whose bursts carry across bit 32. Acknowledge delays vary between zero and two cycles. Stops are placed on a buffer's final burst and on a mid-buffer burst, so both endings of a stopped run are compared against the expected stream.

// File: rtl/dds_pkg.sv
`timescale 1ns/1ps
package dds_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_BURST,
    S_STATUS
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadFirst;  // begin a run at entry 0
    logic burstDone;  // current burst acknowledged
    logic bufDone;    // completion word acknowledged, advance entry
    logic lock;       // run active: configuration is frozen
  } seqStrobe_t;

  localparam int unsigned FIELD_LO  = 0;
  localparam int unsigned FIELD_HI  = 1;
  localparam int unsigned FIELD_LEN = 2;
  localparam int unsigned CMD_START = 0;
  localparam int unsigned CMD_STOP  = 1;

endpackage

// File: rtl/dds_ctrl.sv
`timescale 1ns/1ps
module dds_ctrl
  import dds_pkg::*;
#(
  parameter int unsigned REG_AW    = 6,
  parameter int unsigned CTRL_WORD = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [1:0]        cmdBits,
  input  logic              reqAck,
  input  logic              statAck,
  input  logic              lastBurst,
  output logic              reqValid,
  output logic              statValid,
  output seqStrobe_t        strb
);

  seqState_t state, nextState;
  logic stopPending;
  logic cmdWrite, startCmd, stopCmd, stopReq;

  assign cmdWrite = regWrEn && (regAddr == REG_AW'(CTRL_WORD));
  assign startCmd = cmdWrite && cmdBits[CMD_START] && !cmdBits[CMD_STOP];
  assign stopCmd  = cmdWrite && cmdBits[CMD_STOP];
  assign stopReq  = stopPending || stopCmd;

  assign reqValid  = (state == S_BURST);
  assign statValid = (state == S_STATUS);

  always_comb begin
    nextState = state;
    strb      = '0;
    strb.lock = (state != S_IDLE);
    unique case (state)
      S_IDLE: begin
        if (startCmd) begin
          strb.loadFirst = 1'b1;
          nextState      = S_BURST;
        end
      end
      S_BURST: begin
        if (reqAck) begin
          strb.burstDone = 1'b1;
          if (lastBurst)    nextState = S_STATUS;
          else if (stopReq) nextState = S_IDLE;
        end
      end
      S_STATUS: begin
        if (statAck) begin
          strb.bufDone = 1'b1;
          nextState    = stopReq ? S_IDLE : S_BURST;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      stopPending <= 1'b0;
    end else begin
      state <= nextState;
      if (nextState == S_IDLE)
        stopPending <= 1'b0;
      else if (stopCmd && state != S_IDLE)
        stopPending <= 1'b1;
    end
  end

endmodule

// File: rtl/dds_datapath.sv
`timescale 1ns/1ps
module dds_datapath
  import dds_pkg::*;
#(
  parameter int unsigned ENTRIES     = 8,
  parameter int unsigned ADDR_W      = 64,
  parameter int unsigned LEN_W       = 32,
  parameter int unsigned BURST_BYTES = 256,
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned IDX_PAY_W   = 8,
  parameter int unsigned REG_AW      = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWrEn,
  input  logic [REG_AW-1:0]          regAddr,
  input  logic [31:0]                regWrData,
  input  seqStrobe_t                 strb,
  output logic                       lastBurst,
  output logic [ADDR_W-1:0]          reqAddr,
  output logic [ADDR_W-1:0]          statAddr,
  output logic [CNT_W+IDX_PAY_W-1:0] statData
);

  localparam int unsigned IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int unsigned SHIFT   = $clog2(BURST_BYTES);
  localparam int unsigned HI_W    = ADDR_W - 32;
  localparam int unsigned STAT_LO = 4 * ENTRIES + 1;
  localparam int unsigned STAT_HI = 4 * ENTRIES + 2;

  logic [ADDR_W-1:0] tblAddr [ENTRIES];
  logic [LEN_W-1:0]  tblLen  [ENTRIES];
  logic              regOpen;

  assign regOpen = regWrEn && !strb.lock;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    localparam logic [REG_AW-1:0] W_LO  = REG_AW'(4 * e + FIELD_LO);
    localparam logic [REG_AW-1:0] W_HI  = REG_AW'(4 * e + FIELD_HI);
    localparam logic [REG_AW-1:0] W_LEN = REG_AW'(4 * e + FIELD_LEN);
    logic [ADDR_W-1:0] addrQ;
    logic [LEN_W-1:0]  lenQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        addrQ <= '0;
        lenQ  <= '0;
      end else if (regOpen) begin
        if (regAddr == W_LO)  addrQ[31:0]       <= regWrData;
        if (regAddr == W_HI)  addrQ[ADDR_W-1:32] <= regWrData[HI_W-1:0];
        if (regAddr == W_LEN) lenQ              <= LEN_W'(regWrData);
      end
    end

    assign tblAddr[e] = addrQ;
    assign tblLen[e]  = lenQ;
  end

  logic [ADDR_W-1:0] statAddrQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statAddrQ <= '0;
    end else if (regOpen) begin
      if (regAddr == REG_AW'(STAT_LO)) statAddrQ[31:0]       <= regWrData;
      if (regAddr == REG_AW'(STAT_HI)) statAddrQ[ADDR_W-1:32] <= regWrData[HI_W-1:0];
    end
  end

  function automatic logic [LEN_W-1:0] toBursts(input logic [LEN_W-1:0] len);
    logic [LEN_W-1:0] b;
    b = len >> SHIFT;
    return (b == '0) ? LEN_W'(1) : b;
  endfunction

  logic [IDX_W-1:0]  curIdx, nextIdx;
  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  remBursts;
  logic [CNT_W-1:0]  doneCnt;

  assign nextIdx   = (curIdx == IDX_W'(ENTRIES - 1)) ? '0 : curIdx + IDX_W'(1);
  assign lastBurst = (remBursts == LEN_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx    <= '0;
      curAddr   <= '0;
      remBursts <= '0;
      doneCnt   <= '0;
    end else if (strb.loadFirst) begin
      curIdx    <= '0;
      curAddr   <= tblAddr[0];
      remBursts <= toBursts(tblLen[0]);
      doneCnt   <= '0;
    end else if (strb.burstDone) begin
      curAddr   <= curAddr + ADDR_W'(BURST_BYTES);
      remBursts <= remBursts - LEN_W'(1);
      if (lastBurst) doneCnt <= doneCnt + CNT_W'(1);
    end else if (strb.bufDone) begin
      curIdx    <= nextIdx;
      curAddr   <= tblAddr[nextIdx];
      remBursts <= toBursts(tblLen[nextIdx]);
    end
  end

  assign reqAddr  = curAddr;
  assign statAddr = statAddrQ;
  assign statData = {doneCnt, IDX_PAY_W'(curIdx)};

endmodule

// File: rtl/dma_dest_seq.sv
`timescale 1ns/1ps
module dma_dest_seq
  import dds_pkg::*;
#(
  parameter int unsigned ENTRIES     = 8,
  parameter int unsigned ADDR_W      = 64,
  parameter int unsigned LEN_W       = 32,
  parameter int unsigned BURST_BYTES = 256,
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned REG_AW      = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [31:0]         regWrData,
  output logic                reqValid,
  output logic [ADDR_W-1:0]   reqAddr,
  output logic [LEN_W-1:0]    reqBytes,
  input  logic                reqAck,
  output logic                statValid,
  output logic [ADDR_W-1:0]   statAddr,
  output logic [CNT_W+7:0]    statData,
  input  logic                statAck
);

  localparam int unsigned CTRL_WORD = 4 * ENTRIES;

  seqStrobe_t strb;
  logic       lastBurst;

  dds_ctrl #(
    .REG_AW   (REG_AW),
    .CTRL_WORD(CTRL_WORD)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .cmdBits  (regWrData[1:0]),
    .reqAck   (reqAck),
    .statAck  (statAck),
    .lastBurst(lastBurst),
    .reqValid (reqValid),
    .statValid(statValid),
    .strb     (strb)
  );

  dds_datapath #(
    .ENTRIES    (ENTRIES),
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .BURST_BYTES(BURST_BYTES),
    .CNT_W      (CNT_W),
    .IDX_PAY_W  (8),
    .REG_AW     (REG_AW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .strb     (strb),
    .lastBurst(lastBurst),
    .reqAddr  (reqAddr),
    .statAddr (statAddr),
    .statData (statData)
  );

  assign reqBytes = LEN_W'(BURST_BYTES);

endmodule

// File: rtl/dds_checker.sv
`timescale 1ns/1ps
module dds_checker #(
  parameter int unsigned ADDR_W      = 64,
  parameter int unsigned BURST_BYTES = 256,
  parameter int unsigned REG_AW      = 6,
  parameter int unsigned CTRL_WORD   = 32,
  parameter int unsigned STAT_W      = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regAddr,
  input logic              stopBit,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqAck,
  input logic              statValid,
  input logic [ADDR_W-1:0] statAddr,
  input logic [STAT_W-1:0] statData,
  input logic              statAck
);

  logic stopWr;
  assign stopWr = regWrEn && (regAddr == REG_AW'(CTRL_WORD)) && stopBit;

  p_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && statValid));

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqAck |=> reqValid && $stable(reqAddr));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqAck |=> !reqValid || (reqAddr == $past(reqAddr) + ADDR_W'(BURST_BYTES)));

  p_stat_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    statValid && !statAck |=> statValid && $stable(statData) && $stable(statAddr));

  p_stop_burst_r9: assert property (@(posedge clk) disable iff (!rstN)
    stopWr && reqValid && reqAck |=> !reqValid);

  p_stop_status_r9: assert property (@(posedge clk) disable iff (!rstN)
    stopWr && statValid && statAck |=> !reqValid && !statValid);

endmodule

bind dma_dest_seq dds_checker #(
  .ADDR_W     (ADDR_W),
  .BURST_BYTES(BURST_BYTES),
  .REG_AW     (REG_AW),
  .CTRL_WORD  (4 * ENTRIES),
  .STAT_W     (CNT_W + 8)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .stopBit  (regWrData[1]),
  .reqValid (reqValid),
  .reqAddr  (reqAddr),
  .reqAck   (reqAck),
  .statValid(statValid),
  .statAddr (statAddr),
  .statData (statData),
  .statAck  (statAck)
);

// File: tb/dma_dest_seq_tb.sv
`timescale 1ns/1ps
module dma_dest_seq_tb;

  localparam int ENTRIES = 4;
  localparam int CTRL    = 4 * ENTRIES;
  localparam int SLO     = CTRL + 1;
  localparam int SHI     = CTRL + 2;

  logic        clk = 0;
  logic        rstN = 0;
  logic        regWrEn = 0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        reqValid, statValid;
  logic [63:0] reqAddr, statAddr;
  logic [31:0] reqBytes, statData;
  logic        reqAck = 0, statAck = 0;

  dma_dest_seq #(.ENTRIES(ENTRIES)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqBytes(reqBytes), .reqAck(reqAck),
    .statValid(statValid), .statAddr(statAddr), .statData(statData), .statAck(statAck)
  );

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model and scoreboard ----------------
  typedef struct {
    bit          isStat;
    logic [63:0] addr;
    logic [31:0] data;
    string       tag;
  } ev_t;

  ev_t expQ[$];
  logic [63:0] tbAddr [ENTRIES];
  logic [31:0] tbLen  [ENTRIES];
  logic [63:0] tbStat;
  int mIdx, mRem, mCnt;
  logic [63:0] mAddr;

  function automatic int burstsOf(input logic [31:0] len);
    int b;
    b = int'(len >> 8);
    return (b == 0) ? 1 : b;
  endfunction

  task automatic modelStart();
    mIdx = 0; mAddr = tbAddr[0]; mRem = burstsOf(tbLen[0]); mCnt = 0;
  endtask

  task automatic expectBursts(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      ev_t e;
      e.isStat = 0; e.addr = mAddr; e.data = '0; e.tag = tag;
      expQ.push_back(e);
      mAddr += 64'd256;
      mRem--;
      if (mRem == 0) begin
        ev_t s;
        mCnt++;
        s.isStat = 1; s.addr = tbStat; s.data = {mCnt[23:0], 8'(mIdx)}; s.tag = {tag, " R6"};
        expQ.push_back(s);
        mIdx = (mIdx + 1) % ENTRIES;
        mAddr = tbAddr[mIdx];
        mRem = burstsOf(tbLen[mIdx]);
      end
    end
  endtask

  // ---------------- monitor: compares and acknowledges ----------------
  bit seen = 0;
  int waitCnt = 0, evNum = 0, reqDone = 0, ackLimit = 0;
  bit overlapSeen = 0;

  always @(negedge clk) begin
    reqAck  = 0;
    statAck = 0;
    if (rstN) begin
      if (reqValid && statValid) overlapSeen = 1;
      if ((reqValid || statValid) && !seen) begin
        if (expQ.size() == 0) begin
          check(0, "R9", "unexpected transfer", reqValid ? reqAddr : statAddr, 64'h0);
        end else begin
          ev_t e;
          e = expQ.pop_front();
          if (reqValid)
            check(!e.isStat && reqAddr == e.addr, e.tag, "burst address", reqAddr, e.addr);
          else begin
            check(e.isStat && statData == e.data, e.tag, "status data", 64'(statData), 64'(e.data));
            check(statAddr == e.addr, e.tag, "status address", statAddr, e.addr);
          end
        end
        seen = 1;
        waitCnt = evNum % 3;
        evNum++;
      end
      if (seen) begin
        if (waitCnt > 0) waitCnt--;
        else if (statValid) begin statAck = 1; seen = 0; end
        else if (reqValid && reqDone < ackLimit) begin reqAck = 1; reqDone++; seen = 0; end
      end
    end
  end

  // ---------------- driver tasks ----------------
  task automatic regWrite(input int a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = 6'(a); regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic quietCheck(input int n, input string tag);
    bit ok;
    ok = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      if (reqValid || statValid) ok = 0;
    end
    check(ok, tag, "outputs idle", {62'b0, reqValid, statValid}, 64'h0);
  endtask

  task automatic waitOutstanding(input int k);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); #1;
      if (reqDone == k - 1 && reqValid && !reqAck) break;
    end
  endtask

  task automatic stopRun(input int k, input string tag);
    waitOutstanding(k);
    regWrite(CTRL, 32'h2);
    ackLimit = k;
    repeat (30) @(negedge clk);
    #1;
    check(expQ.size() == 0, tag, "expected transfers left", 64'(expQ.size()), 64'h0);
    quietCheck(10, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    check(0, "WDOG", "watchdog expired", 64'h0, 64'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tbAddr[0] = 64'h0000_0001_0000_0000; tbLen[0] = 32'd512;
    tbAddr[1] = 64'h0000_0000_0000_2000; tbLen[1] = 32'd256;
    tbAddr[2] = 64'h0000_0000_FFFF_FF00; tbLen[2] = 32'd868;
    tbAddr[3] = 64'h4000_0000_0000_5000; tbLen[3] = 32'd0;
    tbStat    = 64'h0000_00AB_CDEF_0040;

    repeat (3) @(negedge clk);
    rstN = 1;
    quietCheck(10, "R1");

    for (int e = 0; e < ENTRIES; e++) begin
      regWrite(4 * e + 0, tbAddr[e][31:0]);
      regWrite(4 * e + 1, tbAddr[e][63:32]);
      regWrite(4 * e + 2, tbLen[e]);
    end
    regWrite(SLO, tbStat[31:0]);
    regWrite(SHI, tbStat[63:32]);
    quietCheck(5, "R1");

    // stop while idle, and start with stop set: nothing runs
    regWrite(CTRL, 32'h2);
    regWrite(CTRL, 32'h3);
    quietCheck(10, "R10");

    // run 1: full lap plus wrap, writes during run ignored
    modelStart();
    ackLimit = 9;
    expectBursts(7, "R4 R5");
    expectBursts(3, "R2 R7 R10");
    regWrite(CTRL, 32'h1);
    #1;
    check(reqValid == 1'b1, "R3", "request after start", 64'(reqValid), 64'h1);
    check(reqAddr == tbAddr[0], "R3", "first address", reqAddr, tbAddr[0]);
    check(reqBytes == 32'd256, "R4", "burst bytes", 64'(reqBytes), 64'd256);
    regWrite(0, 32'hDEAD_0000);
    regWrite(2, 32'd4096);
    regWrite(SLO, 32'h0);
    regWrite(CTRL, 32'h1);
    stopRun(10, "R9");

    // run 2: counter restart, original table intact
    reqDone = 0;
    modelStart();
    ackLimit = 2;
    expectBursts(3, "R2 R8");
    regWrite(CTRL, 32'h1);
    stopRun(3, "R9");

    // run 3: stop on a mid-buffer burst, no completion word
    reqDone = 0;
    modelStart();
    ackLimit = 0;
    expectBursts(1, "R9");
    regWrite(CTRL, 32'h1);
    stopRun(1, "R9");

    check(!overlapSeen, "R11", "request and status overlap", 64'(overlapSeen), 64'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule